// File: doc/BRIEF.md
# Error Injection Capability Register Controller

This block is the configuration-space register set of an endpoint's error-injection extended capability. It holds three 32-bit dwords: a capability header, a vendor-specific header and a control register. Configuration writes and reads are decoded by dword offset. The two headers and the identifier half of the control register return fixed values. The mode bits, the error code and the severity bit can be written by software and read back.

When software sets the immediate-injection bit, the block examines the programmed error code and reports it. Codes below eight are correctable. Codes from 8 to 24 are uncorrectable, and their severity comes from one of two sources. If the endpoint carries AER, a per-error severity mask decides. If it does not, the fatal-treatment bit decides. Codes above 24 are flagged as an invalid configuration and produce no report. The trigger bit always clears itself once the request has been handled. A report is only raised while error reporting is enabled in the endpoint's device control.

The corrupt-DMA and poison mode bits are passed out as levels, for the DMA and memory paths that use them.

Top module: `errinj_cap_regs`

## Requirements
- R1: A read at dword offset 0 (byte 0x0) returns bits 15:0 = 0x0023, bits 19:16 = 0x1 and bits 31:20 = the NEXT_OFFSET parameter. Writes to this dword have no effect.
- R2: A read at dword offset 1 (byte 0x4) returns bits 15:0 = 0x13B5, bits 19:16 = 0x0 and bits 31:20 = 0x00C. Writes to this dword have no effect.
- R3: The control dword (byte 0x8) has the following fields:
  - bits 15:0 read 0x0001;
  - bit 16 is corrupt-DMA;
  - bit 17 is the trigger;
  - bit 18 is poison;
  - bit 19 always reads 0;
  - bits 30:20 are the 11-bit error code;
  - bit 31 is fatal treatment.

  After reset the dword reads 0x00000001.
- R4: Write data on bits 15:0 and bit 19 of the control dword is discarded. Reads at any dword offset of 3 or more return 0.
- R5: A write that sets bit 17 is taken at clock edge N. Bit 17 reads 1 between edges N and N+1 and reads 0 after edge N+1.
- R6: A trigger with code 0x00 to 0x07 produces a report with severity 2'b00 (correctable).
- R7: Without AER, a trigger with code 0x08 to 0x18 produces severity 2'b10 (fatal) when bit 31 is 1, and 2'b01 (non-fatal) when bit 31 is 0.
- R8: With AER, bit 31 is ignored for uncorrectable codes. Mask bit (code − 8) gives fatal (2'b10) when it is 1 and non-fatal (2'b01) when it is 0.
- R9: A trigger with a code of 0x19 or above produces no report. The invalid-configuration output pulses for the single cycle between edges N+1 and N+2, and the trigger still clears.
- R10: While err_report_en is low when the trigger is handled, no report is produced and the trigger still clears.
- R11: A report is a one-cycle rpt_valid pulse between edges N+1 and N+2. During that pulse, rpt_code carries the low 5 bits of the code.
- R12: corrupt_dma_mode and poison_mode follow control bits 16 and 18, from the edge at which the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Byte address within the capability; bits 1:0 ignored |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| err_report_en | input | 1 | Error reporting enabled in device control |
| aer_sev_mask | input | 17 | AER uncorrectable severity, bit i for code 8+i |
| corrupt_dma_mode | output | 1 | Corrupt-DMA mode level |
| poison_mode | output | 1 | Poison mode level |
| rpt_valid | output | 1 | One-cycle error report pulse |
| rpt_sev | output | 2 | 00 correctable, 01 non-fatal, 10 fatal |
| rpt_code | output | 5 | Reported error code |
| cfg_invalid_pulse | output | 1 | Invalid-code trigger pulse |

## Verification
The bench builds two instances that share one stimulus stream. The first uses NEXT_OFFSET = 0x150 and AER_PRESENT = 0, and the second uses NEXT_OFFSET = 0 and AER_PRESENT = 1. The same write therefore yields fatal on one instance and non-fatal on the other, which shows that bit 31 is overridden by the mask. The non-zero offset shows that the header parameter reaches the read path.

// File: rtl/errinj_pkg.sv
package errinj_pkg;

    localparam int DATA_W       = 32;
    localparam int CODE_W       = 11;
    localparam int RPT_CODE_W   = 5;
    localparam int NUM_CORR     = 8;
    localparam int NUM_UNCORR   = 17;
    localparam int FIRST_UNCORR = NUM_CORR;
    localparam int LAST_VALID   = NUM_CORR + NUM_UNCORR - 1;

    localparam logic [15:0] HDR_CAP_ID  = 16'h0023;
    localparam logic [3:0]  HDR_CAP_VER = 4'h1;
    localparam logic [15:0] VS_VENDOR   = 16'h13B5;
    localparam logic [3:0]  VS_REV      = 4'h0;
    localparam logic [11:0] VS_LENGTH   = 12'h00C;
    localparam logic [15:0] CTL_ID      = 16'h0001;

    localparam int DW_HDR  = 0;
    localparam int DW_VS   = 1;
    localparam int DW_CTRL = 2;

    localparam int POS_DMA    = 16;
    localparam int POS_TRIG   = 17;
    localparam int POS_POISON = 18;
    localparam int POS_CODE   = 20;
    localparam int POS_FATAL  = 31;

    typedef enum logic [1:0] {
        SEV_CORR     = 2'b00,
        SEV_NONFATAL = 2'b01,
        SEV_FATAL    = 2'b10
    } sev_e;

    typedef struct packed {
        logic              uncorr_fatal;
        logic [CODE_W-1:0] code;
        logic              poison;
        logic              trigger;
        logic              corrupt_dma;
    } ctrl_t;

    typedef struct packed {
        sev_e                  sev;
        logic [RPT_CODE_W-1:0] code;
        logic                  invalid;
    } report_t;

    function automatic ctrl_t ctrl_from_wdata(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.uncorr_fatal = d[POS_FATAL];
        c.code         = d[POS_CODE +: CODE_W];
        c.poison       = d[POS_POISON];
        c.trigger      = d[POS_TRIG];
        c.corrupt_dma  = d[POS_DMA];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_dword(input ctrl_t c);
        return {c.uncorr_fatal, c.code, 1'b0, c.poison, c.trigger,
                c.corrupt_dma, CTL_ID};
    endfunction

endpackage

// File: rtl/errinj_ctrl_reg.sv
module errinj_ctrl_reg
    import errinj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_trig,
    output ctrl_t             ctrl_q
);

    // Identifier half and bit 19 carry no storage.
    logic unused_wbits;
    assign unused_wbits = ^{wdata[POS_CODE-1], wdata[POS_DMA-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q <= ctrl_from_wdata(wdata);
        end else if (clr_trig) begin
            ctrl_q.trigger <= 1'b0;
        end
    end

endmodule

// File: rtl/errinj_classifier.sv
module errinj_classifier
    import errinj_pkg::*;
#(
    parameter bit AER_PRESENT = 1'b0
) (
    input  ctrl_t                 ctrl,
    input  logic [NUM_UNCORR-1:0] aer_mask,
    output report_t               res
);

    logic [RPT_CODE_W-1:0] code5;
    logic [RPT_CODE_W-1:0] uc_idx;
    logic                  fatal_sel;

    assign code5  = ctrl.code[RPT_CODE_W-1:0];
    assign uc_idx = code5 - RPT_CODE_W'(FIRST_UNCORR);

    logic unused_ctl;
    assign unused_ctl = ^{ctrl.corrupt_dma, ctrl.poison, ctrl.trigger};

    generate
        if (AER_PRESENT) begin : g_aer
            logic unused_fatal_bit;
            assign unused_fatal_bit = ctrl.uncorr_fatal;
            assign fatal_sel = |(aer_mask & (NUM_UNCORR'(1) << uc_idx));
        end else begin : g_no_aer
            logic unused_mask;
            assign unused_mask = ^aer_mask;
            assign fatal_sel   = ctrl.uncorr_fatal;
        end
    endgenerate

    always_comb begin
        res         = '0;
        res.code    = code5;
        res.invalid = (ctrl.code > CODE_W'(LAST_VALID));
        if (ctrl.code < CODE_W'(NUM_CORR)) begin
            res.sev = SEV_CORR;
        end else begin
            res.sev = fatal_sel ? SEV_FATAL : SEV_NONFATAL;
        end
    end

endmodule

// File: rtl/errinj_injector.sv
module errinj_injector
    import errinj_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig,
    input  report_t               cls,
    input  logic                  report_en,
    output logic                  clr_trig,
    output logic                  rpt_valid,
    output sev_e                  rpt_sev,
    output logic [RPT_CODE_W-1:0] rpt_code,
    output logic                  inv_pulse
);

    assign clr_trig = trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_valid <= 1'b0;
            rpt_sev   <= SEV_CORR;
            rpt_code  <= '0;
            inv_pulse <= 1'b0;
        end else begin
            rpt_valid <= trig && !cls.invalid && report_en;
            inv_pulse <= trig && cls.invalid;
            if (trig) begin
                rpt_sev  <= cls.sev;
                rpt_code <= cls.code;
            end
        end
    end

endmodule

// File: rtl/errinj_read_mux.sv
module errinj_read_mux
    import errinj_pkg::*;
#(
    parameter int          IDX_W       = 10,
    parameter logic [11:0] NEXT_OFFSET = 12'h000
) (
    input  logic [IDX_W-1:0]  dw_idx,
    input  ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        if (dw_idx == IDX_W'(DW_HDR)) begin
            rdata = {NEXT_OFFSET, HDR_CAP_VER, HDR_CAP_ID};
        end else if (dw_idx == IDX_W'(DW_VS)) begin
            rdata = {VS_LENGTH, VS_REV, VS_VENDOR};
        end else if (dw_idx == IDX_W'(DW_CTRL)) begin
            rdata = ctrl_to_dword(ctrl);
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/errinj_cap_regs.sv
module errinj_cap_regs
    import errinj_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] NEXT_OFFSET = 12'h000,
    parameter bit          AER_PRESENT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr_en,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  err_report_en,
    input  logic [NUM_UNCORR-1:0] aer_sev_mask,
    output logic                  corrupt_dma_mode,
    output logic                  poison_mode,
    output logic                  rpt_valid,
    output logic [1:0]            rpt_sev,
    output logic [RPT_CODE_W-1:0] rpt_code,
    output logic                  cfg_invalid_pulse
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] dw_idx;
    logic             wr_ctrl;
    logic             clr_trig;
    logic             trig_bit;
    ctrl_t            ctrl_q;
    report_t          cls;
    sev_e             sev_q;

    logic unused_addr;
    assign unused_addr = ^cfg_addr[1:0];

    assign dw_idx  = cfg_addr[ADDR_W-1:2];
    assign wr_ctrl = cfg_wr_en && (dw_idx == IDX_W'(DW_CTRL));

    errinj_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_ctrl),
        .wdata    (cfg_wdata),
        .clr_trig (clr_trig),
        .ctrl_q   (ctrl_q)
    );

    errinj_classifier #(.AER_PRESENT(AER_PRESENT)) u_cls (
        .ctrl     (ctrl_q),
        .aer_mask (aer_sev_mask),
        .res      (cls)
    );

    errinj_injector u_inj (
        .clk       (clk),
        .rst       (rst),
        .trig      (ctrl_q.trigger),
        .cls       (cls),
        .report_en (err_report_en),
        .clr_trig  (clr_trig),
        .rpt_valid (rpt_valid),
        .rpt_sev   (sev_q),
        .rpt_code  (rpt_code),
        .inv_pulse (cfg_invalid_pulse)
    );

    errinj_read_mux #(.IDX_W(IDX_W), .NEXT_OFFSET(NEXT_OFFSET)) u_rd (
        .dw_idx (dw_idx),
        .ctrl   (ctrl_q),
        .rdata  (cfg_rdata)
    );

    assign rpt_sev          = sev_q;
    assign trig_bit         = ctrl_q.trigger;
    assign corrupt_dma_mode = ctrl_q.corrupt_dma;
    assign poison_mode      = ctrl_q.poison;

endmodule

// File: rtl/errinj_cap_chk.sv
module errinj_cap_chk
    import errinj_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rpt_valid,
    input logic [1:0]            rpt_sev,
    input logic [RPT_CODE_W-1:0] rpt_code,
    input logic                  inv_pulse,
    input logic                  trig_bit,
    input logic                  err_report_en
);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |=> !rpt_valid);

    assert_trig_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid || inv_pulse) |-> !trig_bit);

    assert_no_report_on_invalid_R9: assert property (@(posedge clk) disable iff (rst)
        !(rpt_valid && inv_pulse));

    assert_code_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> (rpt_code <= RPT_CODE_W'(LAST_VALID)));

    assert_inv_single_R9: assert property (@(posedge clk) disable iff (rst)
        inv_pulse |=> !inv_pulse);

    assert_corr_severity_R6: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_code < RPT_CODE_W'(NUM_CORR)) |-> (rpt_sev == 2'b00));

    assert_uncorr_severity_R7: assert property (@(posedge clk) disable iff (rst)
        (rpt_valid && rpt_code >= RPT_CODE_W'(NUM_CORR))
            |-> (rpt_sev == 2'b01 || rpt_sev == 2'b10));

    assert_report_gated_R10: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |-> $past(err_report_en));

endmodule

bind errinj_cap_regs errinj_cap_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rpt_valid     (rpt_valid),
    .rpt_sev       (rpt_sev),
    .rpt_code      (rpt_code),
    .inv_pulse     (cfg_invalid_pulse),
    .trig_bit      (trig_bit),
    .err_report_en (err_report_en)
);

// File: tb/errinj_cap_regs_tb_top.sv
`timescale 1ns/1ps
module errinj_cap_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rep_en = 1'b1;
    logic [16:0] mask = '0;

    logic [31:0] rd0, rd1;
    logic        dma0, dma1, psn0, psn1;
    logic        rv0, rv1, inv0, inv1;
    logic [1:0]  sev0, sev1;
    logic [4:0]  code0, code1;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] sev;
        logic [4:0] code;
        logic       inv;
        string      tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    always #4 clk = ~clk;

    errinj_cap_regs #(.ADDR_W(12), .NEXT_OFFSET(12'h150), .AER_PRESENT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_addr(addr), .cfg_wdata(wdata),
        .cfg_rdata(rd0), .err_report_en(rep_en), .aer_sev_mask(mask),
        .corrupt_dma_mode(dma0), .poison_mode(psn0), .rpt_valid(rv0),
        .rpt_sev(sev0), .rpt_code(code0), .cfg_invalid_pulse(inv0));

    errinj_cap_regs #(.ADDR_W(12), .NEXT_OFFSET(12'h000), .AER_PRESENT(1'b1)) dut_aer_i (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_addr(addr), .cfg_wdata(wdata),
        .cfg_rdata(rd1), .err_report_en(rep_en), .aer_sev_mask(mask),
        .corrupt_dma_mode(dma1), .poison_mode(psn1), .rpt_valid(rv1),
        .rpt_sev(sev1), .rpt_code(code1), .cfg_invalid_pulse(inv1));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic compare_item(input exp_t e, input logic [1:0] s, input logic [4:0] c,
                                input logic iv, input string who);
        vectors++;
        if (iv !== e.inv || (!e.inv && (s !== e.sev || c !== e.code))) begin
            miscompares++;
            $display("FAIL %s %s: actual inv=%0b sev=%0d code=0x%02h expected inv=%0b sev=%0d code=0x%02h",
                     e.tag, who, iv, s, c, e.inv, e.sev, e.code);
        end
    endtask

    // Monitors: pop and compare whenever an instance emits an event.
    always @(negedge clk) begin
        if (!rst && (rv0 || inv0)) begin
            if (q0.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R10 dut_i: actual unexpected event sev=%0d code=0x%02h inv=%0b expected none",
                         sev0, code0, inv0);
            end else begin
                compare_item(q0.pop_front(), sev0, code0, inv0, "dut_i");
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && (rv1 || inv1)) begin
            if (q1.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R10 dut_aer_i: actual unexpected event sev=%0d code=0x%02h inv=%0b expected none",
                         sev1, code1, inv1);
            end else begin
                compare_item(q1.pop_front(), sev1, code1, inv1, "dut_aer_i");
            end
        end
    end

    function automatic bit expect_item(input logic [10:0] code, input logic fatal,
                                       input bit aer, output exp_t e, input string tag);
        e.tag  = tag;
        e.code = code[4:0];
        e.inv  = (code > 11'd24);
        e.sev  = 2'b00;
        if (e.inv) return 1'b1;
        if (!rep_en) return 1'b0;
        if (code >= 11'd8) begin
            if (aer) e.sev = mask[code - 11'd8] ? 2'b10 : 2'b01;
            else     e.sev = fatal ? 2'b10 : 2'b01;
        end
        return 1'b1;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_both(input logic [11:0] a, output logic [31:0] v0, output logic [31:0] v1);
        addr = a;
        #1;
        v0 = rd0;
        v1 = rd1;
    endtask

    task automatic inject(input logic [10:0] code, input logic fatal, input string tag);
        exp_t e;
        logic [31:0] v0, v1;
        if (expect_item(code, fatal, 1'b0, e, tag)) q0.push_back(e);
        if (expect_item(code, fatal, 1'b1, e, tag)) q1.push_back(e);
        wr(12'h008, {fatal, code, 4'b0010, 16'h0000});
        rd_both(12'h008, v0, v1);
        check({31'd0, v0[17]}, 32'd1, "R5 trigger set after write");
        check({31'd0, v1[17]}, 32'd1, "R5 trigger set after write (aer)");
        @(negedge clk);
        rd_both(12'h008, v0, v1);
        check({31'd0, v0[17]}, 32'd0, {tag, " R5 trigger self-clears"});
        check({31'd0, v1[17]}, 32'd0, {tag, " R5 trigger self-clears (aer)"});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] v0, v1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset state
        rd_both(12'h008, v0, v1);
        check(v0, 32'h0000_0001, "R3 control after reset");
        check(v1, 32'h0000_0001, "R3 control after reset (aer)");
        check({30'd0, dma0, psn0}, 32'd0, "R12 modes after reset");

        // R1 / R2 headers
        rd_both(12'h000, v0, v1);
        check(v0, 32'h1501_0023, "R1 capability header");
        check(v1, 32'h0001_0023, "R1 capability header (aer)");
        rd_both(12'h004, v0, v1);
        check(v0, 32'h00C0_13B5, "R2 vendor header");
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h004, 32'h0000_0000);
        rd_both(12'h000, v0, v1);
        check(v0, 32'h1501_0023, "R1 header write ignored");
        rd_both(12'h004, v0, v1);
        check(v1, 32'h00C0_13B5, "R2 header write ignored");

        // R3 / R4 / R12: fields, reserved bit, RO id
        wr(12'h008, 32'hFFFD_0000);
        rd_both(12'h008, v0, v1);
        check(v0, 32'hFFF5_0001, "R4 reserved and id write discarded");
        check(v1, 32'hFFF5_0001, "R3 field readback (aer)");
        check({30'd0, dma0, psn0}, 32'd3, "R12 modes set");
        wr(12'h008, 32'h0001_0000);
        check({30'd0, dma1, psn1}, 32'd2, "R12 poison cleared, dma kept");
        wr(12'h008, 32'h0000_0000);
        check({30'd0, dma0, psn0}, 32'd0, "R12 modes cleared");

        // R4 out-of-range reads
        rd_both(12'h00C, v0, v1);
        check(v0, 32'd0, "R4 read at 0xC");
        rd_both(12'h100, v0, v1);
        check(v1, 32'd0, "R4 read at 0x100");

        // Injection with mask: bits for codes 0x0C and 0x18
        mask = 17'h1_0010;
        inject(11'h000, 1'b0, "R6 R11 code 0x00");
        inject(11'h007, 1'b1, "R6 code 0x07 fatal bit set");
        inject(11'h008, 1'b1, "R7 R8 code 0x08 bit31=1");
        inject(11'h00C, 1'b0, "R7 R8 code 0x0C bit31=0");
        inject(11'h018, 1'b0, "R7 R8 code 0x18 bit31=0");
        inject(11'h013, 1'b0, "R7 R8 code 0x13 both non-fatal");
        inject(11'h019, 1'b1, "R9 code 0x19 invalid");
        inject(11'h7FF, 1'b0, "R9 code 0x7FF invalid");

        // R10 reporting disabled
        rep_en = 1'b0;
        inject(11'h003, 1'b0, "R10 code 0x03 disabled");
        inject(11'h00C, 1'b1, "R10 code 0x0C disabled");
        inject(11'h01A, 1'b0, "R9 R10 invalid while disabled");
        rep_en = 1'b1;
        inject(11'h005, 1'b0, "R11 code 0x05 after re-enable");

        repeat (4) @(negedge clk);
        check(q0.size(), 0, "R11 all expected events seen");
        check(q1.size(), 0, "R11 all expected events seen (aer)");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule